// File: doc/BRIEF.md
# Per-Processor Local Register Window

This block keeps one small register file per virtual processor (VP) and gives software two ways to reach it. An access through the local window lands in the copy belonging to the VP that issued it, named by the requester-ID input. An access through the other window is decoded the same way. It lands in the copy of whichever VP the requester's own other-address register points at.

Each copy holds a control word, a local pending bit for the compare interrupt, a six-bit local mask, a compare-map word, the other-address pointer, an identity word and the compare value. The shared counter and its comparison logic sit outside the block. The block receives one compare-expired pulse per VP and exports every VP's compare value to that timer.

The compare interrupt of each VP is merged into that VP's interrupt pins, together with shared interrupt sources that arrive already routed per VP and pin. Register offsets, as word indices on `req_addr`, are:
- 0: control
- 1: pending
- 2: mask (read)
- 3: mask-clear
- 4: mask-set
- 5: compare-map
- 6: other-address
- 7: identity
- 8: compare-low
- 9: compare-high

Top module: `vp_local_window`

## Requirements
- R1: A read request (`req_valid` high, `req_write` low) is answered by `rsp_valid` high with data in `rsp_rdata` on the following cycle. Write requests produce no response. Offsets 3, 4 and any offset above 9 read 0.
- R2: After reset the registers hold these values, and all `vp_pin` outputs are low:
  - control: 0
  - pending: 0
  - mask: 0x32
  - compare-map: 0x80000000
  - other-address: 0
  - compare: 0xFFFFFFFF
- R3: With `req_other` low, the access targets VP `req_vp`. Reading identity returns the index of the VP that was accessed.
- R4: With `req_other` high, the access targets the VP held in the requester's other-address register. A write to other-address takes effect only when the value is below NUM_VP; otherwise the register keeps its value.
- R5: Writes to control are dropped, so control always reads 0. Compare-high always reads 0.
- R6: Writing 1s to mask-clear clears those mask bits, and writing 1s to mask-set sets them. Only bits [5:0] exist. Bit 1 is the compare mask bit.
- R7: A compare-map write whose pin field [5:0] exceeds NUM_PIN-1 is ignored. Otherwise only the map-to-pin flag (bit 31) and the pin field are stored, and every other bit reads 0.
- R8: A pulse on `cmp_expire[v]` sets bit 1 of VP v's pending register and leaves every other VP unchanged.
- R9: A write to compare-low stores the value, which is readable at offset 8 and on `cmp_value`. The same write clears pending bit 1, and it wins over an expiry pulse in the same cycle.
- R10: `vp_pin[v*NUM_PIN+p]` goes high one cycle after the pending bit, mask bit 1 and map-to-pin flag of VP v are all set and its pin field equals p.
- R11: `shared_pin[i]` high makes `vp_pin[i]` high one cycle later, ORed with the compare term.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_other | input | 1 | 1 = other window, 0 = local window |
| req_vp | input | VP_W | Index of the requesting VP |
| req_addr | input | 4 | Register word offset |
| req_wdata | input | 32 | Write data |
| cmp_expire | input | NUM_VP | Per-VP compare-expired pulse |
| shared_pin | input | NUM_VP*NUM_PIN | Routed shared sources, VP-major |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| vp_pin | output | NUM_VP*NUM_PIN | Registered interrupt pins, VP-major |
| cmp_value | output | NUM_VP*CMP_W | Compare value of each VP, for the external timer |

## Verification
Read data is due one cycle after the request edge. A write or expiry pulse becomes visible to a read issued on the next cycle. It reaches `vp_pin` two edges after the stimulus, because the pin merge is a second register stage. A shared source reaches its pin after one edge. The driver queues each expected read word at the cycle the request is issued, and the monitor pops it at the falling edge after `rsp_valid` rises. Pin checks wait exactly the latency above and sample on the falling edge.

// File: rtl/vplw_pkg.sv
package vplw_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 4;
  localparam int MASK_W   = 6;
  localparam int MAP_PW   = 6;
  localparam int CMP_BIT  = 1;
  localparam int FLAG_BIT = 31;
  localparam logic [MASK_W-1:0] MASK_RST = 6'h32;

  typedef enum logic [ADDR_W-1:0] {
    RG_CTRL  = 4'd0,
    RG_PEND  = 4'd1,
    RG_MASK  = 4'd2,
    RG_MCLR  = 4'd3,
    RG_MSET  = 4'd4,
    RG_CMAP  = 4'd5,
    RG_OTHER = 4'd6,
    RG_IDENT = 4'd7,
    RG_CMPLO = 4'd8,
    RG_CMPHI = 4'd9
  } reg_e;
endpackage

// File: rtl/vplw_target.sv
module vplw_target #(
  parameter int NUM_VP = 4,
  localparam int VP_W = (NUM_VP > 1) ? $clog2(NUM_VP) : 1
) (
  input  logic                   req_other,
  input  logic [VP_W-1:0]        req_vp,
  input  logic [NUM_VP*VP_W-1:0] other_flat,
  output logic [VP_W-1:0]        tgt
);
  always_comb begin
    tgt = req_vp;
    if (req_other) tgt = other_flat[req_vp*VP_W +: VP_W];
  end
endmodule

// File: rtl/vplw_slot.sv
module vplw_slot import vplw_pkg::*; #(
  parameter int NUM_VP  = 4,
  parameter int NUM_PIN = 6,
  parameter int CMP_W   = 32,
  localparam int VP_W = (NUM_VP > 1) ? $clog2(NUM_VP) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  reg_e              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              expire,
  output logic              pend_cmp,
  output logic [MASK_W-1:0] mask,
  output logic              map_flag,
  output logic [MAP_PW-1:0] map_pin,
  output logic [VP_W-1:0]   other,
  output logic [CMP_W-1:0]  cmp
);
  localparam logic [MAP_PW-1:0] PIN_MAX = MAP_PW'(NUM_PIN - 1);
  localparam logic [DATA_W-1:0] VP_LIM  = DATA_W'(NUM_VP);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_cmp <= 1'b0;
      mask     <= MASK_RST;
      map_flag <= 1'b1;
      map_pin  <= '0;
      other    <= '0;
      cmp      <= '1;
    end else begin
      if (expire) pend_cmp <= 1'b1;
      if (wr_en) begin
        case (wr_sel)
          RG_MCLR: mask <= mask & ~wr_data[MASK_W-1:0];
          RG_MSET: mask <= mask | wr_data[MASK_W-1:0];
          RG_CMAP: begin
            if (wr_data[MAP_PW-1:0] <= PIN_MAX) begin
              map_flag <= wr_data[FLAG_BIT];
              map_pin  <= wr_data[MAP_PW-1:0];
            end
          end
          RG_OTHER: begin
            if (wr_data < VP_LIM) other <= wr_data[VP_W-1:0];
          end
          RG_CMPLO: begin
            cmp      <= wr_data[CMP_W-1:0];
            pend_cmp <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/vplw_pin_merge.sv
module vplw_pin_merge import vplw_pkg::*; #(
  parameter int NUM_PIN = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_PIN-1:0] shared,
  input  logic               pend_cmp,
  input  logic               mask_cmp,
  input  logic               map_flag,
  input  logic [MAP_PW-1:0]  map_pin,
  output logic [NUM_PIN-1:0] pins
);
  logic               cmp_live;
  logic [NUM_PIN-1:0] nxt;

  assign cmp_live = pend_cmp & mask_cmp & map_flag;

  always_comb begin
    for (int p = 0; p < NUM_PIN; p++)
      nxt[p] = shared[p] | (cmp_live && (map_pin == MAP_PW'(p)));
  end

  always_ff @(posedge clk) begin
    if (rst) pins <= '0;
    else     pins <= nxt;
  end
endmodule

// File: rtl/vp_local_window.sv
module vp_local_window import vplw_pkg::*; #(
  parameter int NUM_VP  = 4,
  parameter int NUM_PIN = 6,
  parameter int CMP_W   = 32,
  localparam int VP_W = (NUM_VP > 1) ? $clog2(NUM_VP) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic                      req_other,
  input  logic [VP_W-1:0]           req_vp,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [DATA_W-1:0]         req_wdata,
  input  logic [NUM_VP-1:0]         cmp_expire,
  input  logic [NUM_VP*NUM_PIN-1:0] shared_pin,
  output logic                      rsp_valid,
  output logic [DATA_W-1:0]         rsp_rdata,
  output logic [NUM_VP*NUM_PIN-1:0] vp_pin,
  output logic [NUM_VP*CMP_W-1:0]   cmp_value
);
  logic [VP_W-1:0]        tgt;
  logic [NUM_VP*VP_W-1:0] other_flat;
  logic                   s_pend [NUM_VP];
  logic [MASK_W-1:0]      s_mask [NUM_VP];
  logic                   s_flag [NUM_VP];
  logic [MAP_PW-1:0]      s_pin  [NUM_VP];
  logic [VP_W-1:0]        s_oth  [NUM_VP];
  logic [CMP_W-1:0]       s_cmp  [NUM_VP];
  reg_e                   sel;
  logic                   do_wr;
  logic                   do_rd;
  logic [DATA_W-1:0]      rd;

  assign sel   = reg_e'(req_addr);
  assign do_wr = req_valid & req_write;
  assign do_rd = req_valid & ~req_write;

  vplw_target #(.NUM_VP(NUM_VP)) u_tgt (
    .req_other (req_other),
    .req_vp    (req_vp),
    .other_flat(other_flat),
    .tgt       (tgt)
  );

  for (genvar v = 0; v < NUM_VP; v++) begin : g_vp
    vplw_slot #(.NUM_VP(NUM_VP), .NUM_PIN(NUM_PIN), .CMP_W(CMP_W)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (do_wr && (tgt == VP_W'(v))),
      .wr_sel  (sel),
      .wr_data (req_wdata),
      .expire  (cmp_expire[v]),
      .pend_cmp(s_pend[v]),
      .mask    (s_mask[v]),
      .map_flag(s_flag[v]),
      .map_pin (s_pin[v]),
      .other   (s_oth[v]),
      .cmp     (s_cmp[v])
    );

    vplw_pin_merge #(.NUM_PIN(NUM_PIN)) u_merge (
      .clk     (clk),
      .rst     (rst),
      .shared  (shared_pin[v*NUM_PIN +: NUM_PIN]),
      .pend_cmp(s_pend[v]),
      .mask_cmp(s_mask[v][CMP_BIT]),
      .map_flag(s_flag[v]),
      .map_pin (s_pin[v]),
      .pins    (vp_pin[v*NUM_PIN +: NUM_PIN])
    );

    assign other_flat[v*VP_W +: VP_W] = s_oth[v];
    assign cmp_value[v*CMP_W +: CMP_W] = s_cmp[v];
  end

  always_comb begin
    rd = '0;
    case (sel)
      RG_PEND:  rd[CMP_BIT] = s_pend[tgt];
      RG_MASK:  rd[MASK_W-1:0] = s_mask[tgt];
      RG_CMAP: begin
        rd[FLAG_BIT]     = s_flag[tgt];
        rd[MAP_PW-1:0]   = s_pin[tgt];
      end
      RG_OTHER: rd[VP_W-1:0] = s_oth[tgt];
      RG_IDENT: rd[VP_W-1:0] = tgt;
      RG_CMPLO: rd[CMP_W-1:0] = s_cmp[tgt];
      default:  rd = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= do_rd;
      rsp_rdata <= do_rd ? rd : '0;
    end
  end
endmodule

// File: rtl/vplw_chk.sv
module vplw_chk import vplw_pkg::*; #(
  parameter int NUM_VP  = 4,
  parameter int NUM_PIN = 6,
  localparam int VP_W = (NUM_VP > 1) ? $clog2(NUM_VP) : 1
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      req_valid,
  input logic                      req_write,
  input logic                      req_other,
  input logic [VP_W-1:0]           req_vp,
  input logic [ADDR_W-1:0]         req_addr,
  input logic [NUM_VP*NUM_PIN-1:0] shared_pin,
  input logic                      rsp_valid,
  input logic [DATA_W-1:0]         rsp_rdata,
  input logic [NUM_VP*NUM_PIN-1:0] vp_pin
);
  // R1
  rd_answer_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_write |=> rsp_valid);

  // R1
  wr_silent_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_write |=> !rsp_valid);

  // R2
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rsp_valid && vp_pin == '0));

  // R3
  ident_local_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_write && !req_other && req_addr == RG_IDENT
    |=> rsp_rdata == DATA_W'($past(req_vp)));

  // R5
  zero_regs_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_write && (req_addr == RG_CTRL || req_addr == RG_CMPHI)
    |=> rsp_rdata == '0);

  for (genvar i = 0; i < NUM_VP*NUM_PIN; i++) begin : g_pin
    // R11
    shared_pass_chk: assert property (@(posedge clk) disable iff (rst)
      shared_pin[i] |=> vp_pin[i]);
  end
endmodule

bind vp_local_window vplw_chk #(.NUM_VP(NUM_VP), .NUM_PIN(NUM_PIN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_other (req_other),
  .req_vp    (req_vp),
  .req_addr  (req_addr),
  .shared_pin(shared_pin),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .vp_pin    (vp_pin)
);

// File: tb/vp_local_window_test.sv
module vp_local_window_test;
  import vplw_pkg::*;
  localparam int NV = 4;
  localparam int NP = 6;
  localparam int CW = 32;
  localparam int VW = 2;

  logic clk = 0;
  logic rst = 1;
  logic req_valid = 0, req_write = 0, req_other = 0;
  logic [VW-1:0] req_vp = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [NV-1:0] cmp_expire = '0;
  logic [NV*NP-1:0] shared_pin = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NV*NP-1:0] vp_pin;
  logic [NV*CW-1:0] cmp_value;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  vp_local_window #(.NUM_VP(NV), .NUM_PIN(NP), .CMP_W(CW)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_other(req_other), .req_vp(req_vp), .req_addr(req_addr),
    .req_wdata(req_wdata), .cmp_expire(cmp_expire), .shared_pin(shared_pin),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .vp_pin(vp_pin),
    .cmp_value(cmp_value)
  );

  // monitor: pops one expected word per response
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R1: unexpected response got %h expected none", rsp_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rsp_rdata !== e) begin
          fails++;
          $display("FAIL %s: got %h expected %h", t, rsp_rdata, e);
        end
      end
    end
  end

  task automatic wr(bit oth, int vp, reg_e a, logic [31:0] d);
    req_valid = 1; req_write = 1; req_other = oth;
    req_vp = VW'(vp); req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(bit oth, int vp, reg_e a, logic [31:0] e, string t);
    req_valid = 1; req_write = 0; req_other = oth;
    req_vp = VW'(vp); req_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic pulse(logic [NV-1:0] m);
    cmp_expire = m;
    @(negedge clk);
    cmp_expire = '0;
  endtask

  task automatic chk_pins(logic [NV*NP-1:0] e, string t);
    @(negedge clk);
    checks++;
    if (vp_pin !== e) begin
      fails++;
      $display("FAIL %s: pins got %h expected %h", t, vp_pin, e);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R2 reset state
    chk_pins('0, "R2 pins");
    rd(0, 0, RG_CTRL,  32'h0, "R2 ctrl");
    rd(0, 0, RG_PEND,  32'h0, "R2 pend");
    rd(0, 0, RG_MASK,  32'h32, "R2 mask");
    rd(0, 0, RG_CMAP,  32'h8000_0000, "R2 cmap");
    rd(0, 0, RG_OTHER, 32'h0, "R2 other");
    rd(0, 0, RG_CMPLO, 32'hFFFF_FFFF, "R2 cmp");
    rd(0, 0, RG_CMPHI, 32'h0, "R5 cmphi");
    rd(0, 0, RG_MCLR,  32'h0, "R1 unmapped read");
    // R3 local identity
    rd(0, 2, RG_IDENT, 32'd2, "R3 ident vp2");
    rd(0, 3, RG_IDENT, 32'd3, "R3 ident vp3");
    // R4 other window
    wr(0, 1, RG_OTHER, 32'd3);
    rd(1, 1, RG_IDENT, 32'd3, "R4 other ident");
    wr(0, 1, RG_OTHER, 32'd4);
    rd(0, 1, RG_OTHER, 32'd3, "R4 rejected other");
    wr(1, 1, RG_CMAP, 32'h8000_0002);
    rd(0, 3, RG_CMAP, 32'h8000_0002, "R4 write via other");
    rd(0, 1, RG_CMAP, 32'h8000_0000, "R4 requester untouched");
    // R5 control dropped
    wr(0, 0, RG_CTRL, 32'h0000_FFFF);
    rd(0, 0, RG_CTRL, 32'h0, "R5 ctrl dropped");
    // R6 mask set / clear
    wr(0, 0, RG_MSET, 32'hFFFF_FFC1);
    rd(0, 0, RG_MASK, 32'h33, "R6 set");
    wr(0, 0, RG_MCLR, 32'h22);
    rd(0, 0, RG_MASK, 32'h11, "R6 clear");
    wr(0, 0, RG_MCLR, 32'hFFFF_FF00);
    rd(0, 0, RG_MASK, 32'h11, "R6 upper bits");
    // R7 compare-map
    wr(0, 0, RG_CMAP, 32'h0000_0006);
    rd(0, 0, RG_CMAP, 32'h8000_0000, "R7 pin too high");
    wr(0, 0, RG_CMAP, 32'h7FFF_FF05);
    rd(0, 0, RG_CMAP, 32'h0000_0005, "R7 field filter");
    wr(0, 0, RG_CMAP, 32'h8000_0003);
    rd(0, 0, RG_CMAP, 32'h8000_0003, "R7 store");
    // R8 / R10 expiry into pin 3 of vp0
    wr(0, 0, RG_MSET, 32'h02);
    pulse(4'b0001);
    chk_pins(24'h000008, "R10 cmp pin");
    rd(0, 0, RG_PEND, 32'h2, "R8 pend set");
    rd(0, 1, RG_PEND, 32'h0, "R8 other vp clean");
    wr(0, 0, RG_MCLR, 32'h02);
    chk_pins(24'h000000, "R10 masked");
    wr(0, 0, RG_MSET, 32'h02);
    chk_pins(24'h000008, "R10 unmasked");
    // R9 compare-low write
    wr(0, 0, RG_CMPLO, 32'h0000_1234);
    chk_pins(24'h000000, "R9 pin cleared");
    rd(0, 0, RG_PEND, 32'h0, "R9 pend cleared");
    rd(0, 0, RG_CMPLO, 32'h0000_1234, "R9 cmp stored");
    checks++;
    if (cmp_value[CW-1:0] !== 32'h1234) begin
      fails++;
      $display("FAIL R9 cmp_value: got %h expected %h", cmp_value[CW-1:0], 32'h1234);
    end
    cmp_expire = 4'b0001;
    wr(0, 0, RG_CMPLO, 32'h55);
    cmp_expire = '0;
    rd(0, 0, RG_PEND, 32'h0, "R9 write beats expiry");
    rd(0, 0, RG_CMPLO, 32'h55, "R9 cmp second");
    // R10 vp2 default map pin0
    pulse(4'b0100);
    chk_pins(24'h001000, "R10 vp2 pin0");
    // R11 shared sources
    shared_pin = 24'h000080;
    chk_pins(24'h001080, "R11 shared");
    shared_pin = 24'h001080;
    wr(0, 2, RG_CMPLO, 32'h77);
    chk_pins(24'h001080, "R11 shared OR after clear");
    shared_pin = '0;
    chk_pins(24'h000000, "R11 shared released");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R1: got %0d missing responses expected 0", exp_q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule